// File: doc/BRIEF.md
# Microprogram Sequencer with Two-Way Conditional Branching

This block is the control store and address sequencer of a microprogrammed control unit. A 256-entry control memory holds 64-bit microwords. Each clock edge fetches the word at the current microaddress into a microinstruction register. The control-signal field of that register drives the outputs. A parent or testbench fills the memory through a write port while reset is held. The sequencer then runs on its own from address 0.

Each microword carries three fields. The first is a one-hot selection of the external condition lines. The second is 32 control signals. The third is an 8-bit branch target. When any selected condition line is high, the next microaddress is the branch target. Otherwise the next microaddress is the current one plus one, wrapping modulo 256. There is no opcode dispatch, so every transfer is either "branch" or "step".

Top module: `ucode_sequencer`

## Requirements
- R1: While rst_ni is low, uaddr_o is 0 and ctrl_o is 0.
- R2: On the first rising clock edge after rst_ni goes high, the word at address 0 is fetched. uaddr_o stays 0 and ctrl_o shows that word's control field.
- R3: Microword layout: bits 63..40 are the condition selection, and bit 40+i selects cond_i[i]. Bits 39..8 are the control field driven on ctrl_o[31:0]. Bits 7..0 are the branch target.
- R4: When the current word selects at least one condition line that is 1, the next uaddr_o is that word's branch target.
- R5: When no selected condition line is 1, the next uaddr_o is the current uaddr_o plus one.
- R6: A word whose selection field is all zeros always steps to the next address, whatever cond_i holds.
- R7: With several selection bits set, the branch is taken when any one of the selected lines is 1.
- R8: Stepping from address 255 gives address 0.
- R9: From the first fetch on, ctrl_o equals the control field of the memory word at uaddr_o in every cycle.
- R10: A write with wr_en_i high stores wr_data_i at wr_addr_i at the rising edge, and the last write to an address wins. Writes are made only while rst_ni is low.
- R11: Condition lines whose selection bit is 0 have no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 24 | External condition lines |
| wr_en_i | input | 1 | Control memory write strobe |
| wr_addr_i | input | 8 | Control memory write address |
| wr_data_i | input | 64 | Control memory write data |
| ctrl_o | output | 32 | Control signals from the microinstruction register |
| uaddr_o | output | 8 | Current microaddress |

## Verification
The bench builds the block with its default parameters: 8-bit microaddress, 24 condition lines and 32 control signals, which together make a 64-bit word. With these values the full 256-word store is loaded in every scenario. Long stepping runs therefore reach the 255-to-0 wrap more than once. Every condition line is exercised as a single selection and inside multi-bit selections.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int unsigned ADDR_W_DEF   = 8;
  localparam int unsigned NUM_COND_DEF = 24;
  localparam int unsigned NUM_CTRL_DEF = 32;

  typedef enum logic {
    FETCH_PRIME = 1'b0,
    FETCH_RUN   = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/ucode_store.sv
module ucode_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ucode_next.sv
module ucode_next #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_COND = 24
) (
  input  logic [NUM_COND-1:0] sel_i,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic [ADDR_W-1:0]   nad_i,
  input  logic [ADDR_W-1:0]   cur_i,
  output logic                take_o,
  output logic [ADDR_W-1:0]   next_o
);
  logic [NUM_COND-1:0] hit;

  for (genvar g = 0; g < NUM_COND; g++) begin : g_gate
    assign hit[g] = sel_i[g] & cond_i[g];
  end

  assign take_o = |hit;
  assign next_o = take_o ? nad_i : cur_i + {{(ADDR_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned NUM_COND = NUM_COND_DEF,
  parameter int unsigned NUM_CTRL = NUM_CTRL_DEF,
  parameter int unsigned WORD_W   = NUM_COND + NUM_CTRL + ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  output logic [NUM_CTRL-1:0] ctrl_o,
  output logic [ADDR_W-1:0]   uaddr_o
);
  localparam int unsigned NAD_LSB  = 0;
  localparam int unsigned CTRL_LSB = ADDR_W;
  localparam int unsigned SEL_LSB  = ADDR_W + NUM_CTRL;

  fetch_state_e      state_q;
  logic [ADDR_W-1:0] uar_q;
  logic [WORD_W-1:0] mir_q;
  logic [WORD_W-1:0] rd_data;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] fetch_addr;
  logic              take;
  logic              run_w;

  ucode_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_store (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(fetch_addr),
    .rd_data_o(rd_data)
  );

  ucode_next #(.ADDR_W(ADDR_W), .NUM_COND(NUM_COND)) i_next (
    .sel_i (mir_q[SEL_LSB +: NUM_COND]),
    .cond_i(cond_i),
    .nad_i (mir_q[NAD_LSB +: ADDR_W]),
    .cur_i (uar_q),
    .take_o(take),
    .next_o(next_addr)
  );

  assign run_w = (state_q == FETCH_RUN);
  // first edge after reset fetches the reset address without advancing
  assign fetch_addr = run_w ? next_addr : uar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FETCH_PRIME;
      uar_q   <= '0;
      mir_q   <= '0;
    end else begin
      state_q <= FETCH_RUN;
      uar_q   <= fetch_addr;
      mir_q   <= rd_data;
    end
  end

  assign ctrl_o  = mir_q[CTRL_LSB +: NUM_CTRL];
  assign uaddr_o = uar_q;
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_COND = 24,
  parameter int unsigned NUM_CTRL = 32,
  parameter int unsigned WORD_W   = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [NUM_COND-1:0] cond_i,
  input logic [NUM_CTRL-1:0] ctrl_o,
  input logic [ADDR_W-1:0]   uaddr_o,
  input logic                run_i,
  input logic [WORD_W-1:0]   mir_i
);
  localparam int unsigned SEL_LSB = ADDR_W + NUM_CTRL;

  logic [NUM_COND-1:0] sel;
  logic [ADDR_W-1:0]   nad;
  assign sel = mir_i[SEL_LSB +: NUM_COND];
  assign nad = mir_i[ADDR_W-1:0];

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (uaddr_o == '0 && ctrl_o == '0)); // R1

  AST_PRIME_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (run_i && uaddr_o == '0)); // R2

  AST_BRANCH_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (|(sel & cond_i))) |=> uaddr_o == $past(nad)); // R4

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(|(sel & cond_i))) |=> uaddr_o == $past(uaddr_o) + 1'b1); // R5

  AST_NO_SEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel == '0) |=> uaddr_o == $past(uaddr_o) + 1'b1); // R6

  AST_WRITE_IN_RESET: assert property (@(posedge clk_i)
    rst_ni |-> !wr_en_i); // R10
endmodule

bind ucode_sequencer ucode_sequencer_chk #(
  .ADDR_W(ADDR_W), .NUM_COND(NUM_COND), .NUM_CTRL(NUM_CTRL), .WORD_W(WORD_W)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .cond_i (cond_i),
  .ctrl_o (ctrl_o),
  .uaddr_o(uaddr_o),
  .run_i  (run_w),
  .mir_i  (mir_q)
);

// File: tb/test_ucode_sequencer.sv
module test_ucode_sequencer;
  localparam int AW = 8;
  localparam int NC = 24;
  localparam int NK = 32;
  localparam int WW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] cond_i = '0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [WW-1:0] wr_data_i = '0;
  logic [NK-1:0] ctrl_o;
  logic [AW-1:0] uaddr_o;

  always #4 clk_i = ~clk_i;

  ucode_sequencer i_ucode_sequencer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ctrl_o(ctrl_o), .uaddr_o(uaddr_o)
  );

  logic [WW-1:0] ref_mem [256];
  logic [AW-1:0] m_addr;
  bit            m_primed;
  int            n_checks = 0;
  int            n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R3 layout: sel [63:40], ctrl [39:8], target [7:0]
  task automatic compare_model(input string tag);
    logic [31:0] exp_ctrl;
    exp_ctrl = m_primed ? ref_mem[m_addr][39:8] : 32'h0;
    chk({tag, " addr"}, 32'(uaddr_o), 32'(m_addr));
    chk({tag, " ctrl"}, ctrl_o, exp_ctrl);
  endtask

  task automatic step(input logic [NC-1:0] c, input string tag);
    logic [WW-1:0] w;
    cond_i = c;
    if (!m_primed) m_primed = 1'b1;
    else begin
      w = ref_mem[m_addr];
      if ((w[63:40] & c) != '0) m_addr = w[7:0];
      else m_addr = m_addr + 8'd1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare_model(tag);
  endtask

  function automatic logic [WW-1:0] gen_word(input int kind, input int a);
    logic [23:0] sel;
    logic [7:0]  nad;
    logic [31:0] ctl;
    ctl = $urandom;
    case (kind)
      0: begin sel = '0; nad = ~8'(a); ctl = {8'(a), ~8'(a), 8'(a) ^ 8'h5a, 8'(a + 1)}; end
      1: begin sel = 24'd1 << (a % 24); nad = 8'(a * 37 + 11); end
      2: begin sel = 24'($urandom & $urandom); nad = 8'($urandom); end
      default: begin
        sel = '0; nad = '0;
        if (a == 0 || a == 1) begin sel = 24'd1 << 5; nad = 8'h80; end
        if (a == 8'h80) begin sel = 24'h800001; nad = 8'h10; end
        if (a == 8'h11) begin sel = 24'h000002; nad = 8'hff; end
      end
    endcase
    return {sel, ctl, nad};
  endfunction

  task automatic load_prog(input int kind);
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_addr = '0;
    m_primed = 1'b0;
    // junk first, overwritten below: last write wins (R10)
    wr_en_i = 1'b1; wr_addr_i = '0; wr_data_i = 64'hdead_beef_0bad_f00d;
    @(negedge clk_i);
    for (int a = 0; a < 256; a++) begin
      ref_mem[a] = gen_word(kind, a);
      wr_addr_i = 8'(a);
      wr_data_i = ref_mem[a];
      @(negedge clk_i);
      chk("R1 reset addr", 32'(uaddr_o), 32'h0);
      chk("R1 reset ctrl", ctrl_o, 32'h0);
    end
    wr_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare_model("R1 released");
    step('0, "R2/R10 first fetch");
  endtask

  initial begin
    // scenario 1: unconditional stepping, wraps twice
    load_prog(0);
    chk("R2 word0 ctrl", ctrl_o, {8'h00, 8'hff, 8'h5a, 8'h01});
    for (int i = 0; i < 600; i++) step(NC'($urandom), "R6/R8/R9");

    // scenario 2: single selection lines
    load_prog(1);
    for (int i = 0; i < 800; i++) step(NC'($urandom), "R3/R4/R5/R11");

    // scenario 3: multi-bit selections with sparse conditions
    load_prog(2);
    for (int i = 0; i < 800; i++) step(NC'($urandom & $urandom & $urandom), "R7/R9");

    // scenario 4: directed values
    load_prog(3);
    step(~(24'd1 << 5), "R11 model");
    chk("R11 unselected lines ignored", 32'(uaddr_o), 32'h01);
    step(24'd1 << 5, "R4 model");
    chk("R4 branch to target", 32'(uaddr_o), 32'h80);
    step(24'h800000, "R7 model");
    chk("R7 one of two selected", 32'(uaddr_o), 32'h10);
    step(24'hffffff, "R6 model");
    chk("R6 no selection steps", 32'(uaddr_o), 32'h11);
    step(24'h000002, "R4 model");
    chk("R4 branch to 255", 32'(uaddr_o), 32'hff);
    step(24'h000000, "R8 model");
    chk("R8 wrap to 0", 32'(uaddr_o), 32'h00);
    step(24'h000000, "R5 model");
    chk("R5 step when clear", 32'(uaddr_o), 32'h01);
    chk("R9 ctrl of word1", ctrl_o, ref_mem[1][39:8]);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule